// File: doc/BRIEF.md
# Freeze-on-Read Statistics Counter

This block is one management statistics counter for a network controller. It counts single-cycle event pulses. Host software reads it one byte at a time through a narrow register path. A multi-byte read is not atomic, so the counter holds its visible value from the first byte of a read to the last. Events that arrive during that window go into a small pending tally and are not lost.

Reading byte 0, the least significant byte, ends the read. At that moment the counter takes its next value. In clear-on-read mode it restarts from the pending tally. In hold-on-read mode the pending tally is added to the held value. A width mode selects 16-bit or 32-bit counting. A sticky threshold status bit, gated by a mask, raises an interrupt when the counter's top bit turns on. The threshold only works in the wide mode.

Top module: `frz_stat_cnt`

## Requirements
- R1: `wide_i`=1 gives a counter of WIDE_W bits (default 32). `wide_i`=0 gives a counter of NARROW_W bits (default 16) that wraps modulo 2^NARROW_W. In that mode every byte above the narrow width reads as 0. `rd_data_o` is combinational and returns byte `rd_sel_i` of the visible value, where byte 0 is bits 7:0.
- R2: When no read is in progress, each cycle with `event_i`=1 adds one to the counter, and the result appears after the next clock edge.
- R3: A read begins with an `rd_en_i` pulse on the top byte: byte WIDE_W/8-1 in wide mode, byte NARROW_W/8-1 in narrow mode. From then on the counter value stays frozen. Reads of the middle bytes do not end the freeze. An event in the cycle that begins the read goes into the pending tally.
- R4: If `clr_mode_i`=1 when byte 0 is read during a freeze, the counter becomes the pending tally. This is 0 when no event arrived during the freeze.
- R5: If `clr_mode_i`=0 when byte 0 is read during a freeze, the counter becomes the held value plus the pending tally, wrapped to the active width. It is unchanged when no event arrived during the freeze.
- R6: An event in the same cycle as the byte-0 read that ends a freeze is counted in the pending tally, so it is included in the post-read value.
- R7: The pending tally saturates at 2^PEND_W-1, which is 255 by default.
- R8: `irq_sts_o` sets when, in wide mode, an update turns on the top bit of the counter. In narrow mode it never sets.
- R9: `irq_sts_o` is sticky. A cycle with `irq_ack_i`=1 clears it, unless a new set arrives in the same cycle, which takes priority. `irq_o` equals `irq_sts_o` AND `irq_mask_i`.
- R10: After reset the counter is 0, no read is in progress, and `irq_sts_o` and `irq_o` are 0. With both mode inputs at 0, the block is in narrow, hold-on-read mode.
- R11: A byte-0 read with no freeze in progress has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | One event per cycle when high |
| wide_i | input | 1 | 1: full width, 0: narrow width |
| clr_mode_i | input | 1 | 1: clear-on-read, 0: hold-on-read |
| rd_en_i | input | 1 | Byte read strobe |
| rd_sel_i | input | SEL_W | Byte index of the read |
| rd_data_o | output | 8 | Selected byte of the visible value |
| irq_mask_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Write-one-to-clear of the status bit |
| irq_sts_o | output | 1 | Sticky threshold status |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume that `wide_i` does not change while a freeze is in progress. The frozen-value and completion properties depend on this. The stimulus changes either mode only when no read sequence is open. The random read sequences always walk the bytes from the top byte down to byte 0 and never restart a read from inside a freeze. The threshold is checked on a second, narrower instance, because the default 32-bit threshold cannot be reached in a short run.

// File: rtl/frz_stat_cnt.sv
`timescale 1ns/1ps
module frz_stat_cnt #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int PEND_W   = 8,
  localparam int SEL_W   = (WIDE_W > 8) ? $clog2(WIDE_W/8) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic             wide_i,
  input  logic             clr_mode_i,
  input  logic             rd_en_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [7:0]       rd_data_o,
  input  logic             irq_mask_i,
  input  logic             irq_ack_i,
  output logic             irq_sts_o,
  output logic             irq_o
);
  localparam logic [SEL_W-1:0] TOP_W = SEL_W'(WIDE_W/8 - 1);
  localparam logic [SEL_W-1:0] TOP_N = SEL_W'(NARROW_W/8 - 1);

  logic [WIDE_W-1:0] cnt_q, cnt_d, act_mask, vis, pend_ext;
  logic [PEND_W-1:0] pend_q, pend_tot;
  logic              frz_q, sts_q, start, done, sts_set;

  assign act_mask = wide_i ? {WIDE_W{1'b1}}
                           : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign vis      = cnt_q & act_mask;
  assign rd_data_o = vis[{rd_sel_i, 3'b000} +: 8];

  assign start    = rd_en_i && !frz_q && (rd_sel_i == (wide_i ? TOP_W : TOP_N));
  assign done     = rd_en_i && frz_q && (rd_sel_i == '0);
  assign pend_tot = pend_q + PEND_W'(event_i && !(&pend_q));
  assign pend_ext = {{(WIDE_W-PEND_W){1'b0}}, pend_tot};

  always_comb begin
    if (done)
      cnt_d = (clr_mode_i ? pend_ext : cnt_q + pend_ext) & act_mask;
    else if (frz_q || start)
      cnt_d = cnt_q;
    else
      cnt_d = (cnt_q + WIDE_W'(event_i)) & act_mask;
  end

  assign sts_set   = wide_i && !cnt_q[WIDE_W-1] && cnt_d[WIDE_W-1];
  assign irq_sts_o = sts_q;
  assign irq_o     = sts_q & irq_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      frz_q  <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      frz_q  <= !done && (frz_q || start);
      pend_q <= (!done && (frz_q || start)) ? pend_tot : '0;
      sts_q  <= sts_set || (sts_q && !irq_ack_i);
    end
  end

  // input assumption: width mode is steady while a read is open
  p_mode_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |-> $stable(wide_i));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && !(rd_en_i && rd_sel_i == '0) |=> $stable(cnt_q));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && rd_en_i && rd_sel_i == '0 && clr_mode_i && !event_i && pend_q == '0
    |=> cnt_q == '0);

  p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && rd_en_i && rd_sel_i == '0 && !clr_mode_i && !event_i && pend_q == '0
    |=> (cnt_q & act_mask) == $past(cnt_q & act_mask));

  p_pend_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && (&pend_q) && !rd_en_i |=> (&pend_q));

  p_no_irq_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i && !sts_q |=> !sts_q);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q && !irq_ack_i |=> sts_q);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q && irq_ack_i && !wide_i |=> !sts_q);
endmodule

// File: tb/frz_stat_cnt_tb.sv
`timescale 1ns/1ps
module frz_stat_cnt_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ev = 0, wide = 0, clr = 0, rd = 0, mask = 0, ack = 0;
  logic [1:0] sel = 0;
  logic [7:0] rdata;
  logic sts, irq;

  logic s_ev = 0, s_wide = 1, s_mask = 0, s_ack = 0;
  logic [7:0] s_rdata;
  logic s_sts, s_irq;

  frz_stat_cnt u_dut (
    .clk(clk), .rst_n(rst_n), .event_i(ev), .wide_i(wide), .clr_mode_i(clr),
    .rd_en_i(rd), .rd_sel_i(sel), .rd_data_o(rdata), .irq_mask_i(mask),
    .irq_ack_i(ack), .irq_sts_o(sts), .irq_o(irq));

  frz_stat_cnt #(.WIDE_W(16), .NARROW_W(8)) u_small (
    .clk(clk), .rst_n(rst_n), .event_i(s_ev), .wide_i(s_wide), .clr_mode_i(1'b0),
    .rd_en_i(1'b0), .rd_sel_i(1'b0), .rd_data_o(s_rdata), .irq_mask_i(s_mask),
    .irq_ack_i(s_ack), .irq_sts_o(s_sts), .irq_o(s_irq));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] m_cnt = 0;
  bit m_frz = 0;
  int m_pend = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] amask();
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [7:0] exp_byte(logic [1:0] s);
    return 8'(((m_cnt & amask()) >> (8 * s)));
  endfunction

  task automatic model_edge();
    int top = wide ? 3 : 1;
    bit st = rd && !m_frz && (int'(sel) == top);
    bit dn = rd && m_frz && (sel == 2'd0);
    int tot = m_pend + int'(ev);
    if (tot > 255) tot = 255;
    if (dn) begin
      m_cnt  = clr ? 32'(tot) : (m_cnt + 32'(tot)) & amask();
      m_frz  = 0;
      m_pend = 0;
    end else if (m_frz || st) begin
      m_frz  = 1;
      m_pend = tot;
    end else begin
      m_cnt = (m_cnt + 32'(ev)) & amask();
    end
  endtask

  task automatic step(string tag, logic e, logic r, logic [1:0] s);
    ev = e; rd = r; sel = s;
    #1;
    chk(tag, rdata, exp_byte(s));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    ev = 0; rd = 0;
  endtask

  task automatic peek(string tag, logic [1:0] s, logic [7:0] exp);
    sel = s;
    #0.2;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int b = 0; b < 4; b++) peek("R10", 2'(b), 8'h00);
    chk("R10", {30'd0, sts, irq}, 32'd0);
    chk("R10", {30'd0, s_sts, s_irq}, 32'd0);

    // R2 / R1 wide counting beyond 16 bits, small threshold run in parallel
    wide = 1;
    for (int i = 0; i < 65541; i++) begin
      s_ev = (i < 32767);
      step("R2", 1'b1, 1'b0, 2'd0);
    end
    s_ev = 0;
    peek("R1", 2'd0, 8'h05); peek("R1", 2'd1, 8'h00);
    peek("R1", 2'd2, 8'h01); peek("R1", 2'd3, 8'h00);
    chk("R8", {31'd0, s_sts}, 32'd0);
    s_ev = 1; step("R2", 1'b0, 1'b0, 2'd0); s_ev = 0;
    chk("R8", {31'd0, s_sts}, 32'd1);
    chk("R9", {31'd0, s_irq}, 32'd0);
    s_mask = 1; #0.2;
    chk("R9", {31'd0, s_irq}, 32'd1);
    repeat (3) step("R9", 1'b0, 1'b0, 2'd0);
    chk("R9", {31'd0, s_sts}, 32'd1);
    s_ack = 1; step("R9", 1'b0, 1'b0, 2'd0); s_ack = 0;
    chk("R9", {30'd0, s_sts, s_irq}, 32'd0);

    // R1 narrow masking, R8 no status in narrow mode
    wide = 0;
    peek("R1", 2'd2, 8'h00); peek("R1", 2'd0, 8'h05);
    s_wide = 0;
    for (int i = 0; i < 258; i++) begin
      s_ev = 1; step("R1", 1'b0, 1'b0, 2'd0);
    end
    s_ev = 0;
    chk("R1", {24'd0, s_rdata}, 32'h02);
    chk("R8", {31'd0, s_sts}, 32'd0);

    // R3 R4 R6 clear mode with events around the freeze
    clr = 1;
    step("R3", 1'b1, 1'b1, 2'd1);
    repeat (3) step("R3", 1'b1, 1'b0, 2'd0);
    peek("R3", 2'd0, 8'h05);
    step("R6", 1'b1, 1'b1, 2'd0);
    peek("R6", 2'd0, 8'h05); peek("R4", 2'd1, 8'h00);
    step("R3", 1'b0, 1'b1, 2'd1);
    step("R3", 1'b0, 1'b1, 2'd0);
    peek("R4", 2'd0, 8'h00);

    // R5 R7 hold mode and saturation
    clr = 0;
    repeat (10) step("R2", 1'b1, 1'b0, 2'd0);
    step("R7", 1'b0, 1'b1, 2'd1);
    repeat (300) step("R7", 1'b1, 1'b0, 2'd0);
    step("R7", 1'b1, 1'b1, 2'd0);
    peek("R7", 2'd0, 8'h09); peek("R7", 2'd1, 8'h01);
    step("R5", 1'b0, 1'b1, 2'd1);
    step("R5", 1'b0, 1'b1, 2'd0);
    peek("R5", 2'd0, 8'h09); peek("R5", 2'd1, 8'h01);
    // R11 stray byte-0 read
    step("R11", 1'b0, 1'b1, 2'd0);
    peek("R11", 2'd0, 8'h09); peek("R11", 2'd1, 8'h01);

    // random mix
    begin
      bit in_seq = 0;
      int nxt = 0;
      for (int i = 0; i < 6000; i++) begin
        logic e = 1'($urandom % 2);
        int r = $urandom % 16;
        if (!in_seq) begin
          if (r == 0) begin
            wide = 1'($urandom % 2);
            clr  = 1'($urandom % 2);
            step("R1", e, 1'b0, 2'($urandom % 4));
          end else if (r == 1) begin
            nxt = wide ? 2 : 0;
            in_seq = 1;
            step("R3", e, 1'b1, wide ? 2'd3 : 2'd1);
          end else if (r == 2) begin
            step("R11", e, 1'b1, 2'd0);
          end else begin
            step("R2", e, 1'b0, 2'($urandom % 4));
          end
        end else if ($urandom % 2 == 1) begin
          step(nxt == 0 ? (clr ? "R4" : "R5") : "R3", e, 1'b1, 2'(nxt));
          if (nxt == 0) in_seq = 0; else nxt--;
        end else begin
          step("R3", e, 1'b0, 2'($urandom % 4));
        end
        if (i % 100 == 0) chk("R8", {30'd0, sts, irq}, 32'd0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule